// File: doc/BRIEF.md
# Column-Serial Parity-Check Syndrome Accumulator

This block builds the parity-check syndrome of a regular hard-decision low-density parity-check decoder. It visits one codeword position per clock. Each position holds one hard-decision bit, taken from the sign of a 2-bit quantized channel sample. A bipolar +1 is stored as logic 0 and a bipolar -1 as logic 1. Three column memories are addressed by the same column pointer. Each one returns the row index of one of the three ones in the current column. The syndrome flip-flops at those rows take in the current bit by XOR.

A pass is started with `start`. The block clears the syndrome register and scans every column from the first to the last, one per clock. It then raises `done` for one cycle. `all_satisfied` shows whether every parity check holds, which is the condition for the decoder to stop. The syndrome vector stays readable so that a later flip stage can use it.

The controller has three states:
- `ST_IDLE`: waits for `start`. Both load ports are open in this state.
- `ST_SCAN`: steps the pointer. It moves to `ST_FINISH` after the last column.
- `ST_FINISH`: signals `done` for one cycle and returns to `ST_IDLE`.

The bit buffer and the column memories are filled through load ports before the pass begins.

Top module: `colsyn_top`

## Requirements
- R1: A sample write stores bit 1 of the 2-bit sample as the hard decision (codes 2'b10 and 2'b11 give logic 1, codes 2'b00 and 2'b01 give logic 0). Bit 0 of the sample has no effect on the result.
- R2: After reset, `busy` and `done` are 0, `syndrome` is all zero and `all_satisfied` is 1.
- R3: A pass holds `busy` high for exactly N_VAR consecutive cycles, one per column, with the pointer moving from column 0 to column N_VAR-1.
- R4: At `done`, `syndrome[r]` equals the XOR of the stored bits of every column whose memory entries name row r.
- R5: When two memories name the same row for one column, that row receives the column's bit twice, so their contributions cancel.
- R6: The syndrome register is cleared at the start of every pass. Repeating a pass on unchanged data gives the same vector.
- R7: `done` is a single-cycle pulse in the cycle after the last column. `busy` is low while `done` is high.
- R8: `all_satisfied` is 1 exactly when every syndrome bit is 0.
- R9: Sample writes and column-memory writes made while `busy` is high are dropped.
- R10: A `start` asserted while `busy` is high neither restarts nor lengthens the pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| smp_wr | input | 1 | Sample write strobe |
| smp_addr | input | $clog2(N_VAR) | Column written by the sample port |
| smp_val | input | 2 | Quantized channel sample; bit 1 is the sign |
| hmem_wr | input | 1 | Column-memory write strobe |
| hmem_sel | input | 2 | Selects which of the three column memories is written (0..2) |
| hmem_addr | input | $clog2(N_VAR) | Column written in the selected memory |
| hmem_row | input | $clog2(N_CHK) | Row index stored for that column |
| start | input | 1 | Begins a pass when idle |
| busy | output | 1 | High while columns are being scanned |
| done | output | 1 | One-cycle pulse at the end of a pass |
| all_satisfied | output | 1 | High when the syndrome vector is all zero |
| syndrome | output | N_CHK | Syndrome vector; bit r is 1 when check r fails |

## Verification
The assertions assume that every row index written into a column memory is below N_CHK. They also assume that `hmem_sel` is only 0, 1 or 2 when a write is made. The bench builds its matrices from modular offsets that stay within the row count, and writes one duplicate-row column on purpose only for R5. The only load-port writes made during a pass are the ones meant to show that they are dropped. Expected syndromes come from the bench's own copy of the row table, computed by parity over small codewords: every single-bit and double-bit error pattern, plus pseudo-random words.

// File: rtl/colsyn_pkg.sv
package colsyn_pkg;
    // Controller states of the column-serial syndrome pass
    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_FINISH = 2'd2
    } colsyn_state_e;

    // Number of ones in each column of the regular code
    localparam int COL_WEIGHT = 3;
endpackage

// File: rtl/colsyn_bitbuf.sv
module colsyn_bitbuf #(
    parameter int N_VAR = 1000,
    localparam int AW = $clog2(N_VAR)
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [1:0]    wr_sample,
    input  logic [AW-1:0] rd_addr,
    output logic          rd_bit
);
    logic [N_VAR-1:0] bits_q;

    // Hard decision is the sign bit of the quantized sample
    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < N_VAR))
            bits_q[wr_addr] <= wr_sample[1];
    end

    assign rd_bit = (int'(rd_addr) < N_VAR) ? bits_q[rd_addr] : 1'b0;
endmodule

// File: rtl/colsyn_rowmem.sv
module colsyn_rowmem #(
    parameter int N_VAR = 1000,
    parameter int N_CHK = 100,
    localparam int AW = $clog2(N_VAR),
    localparam int RW = $clog2(N_CHK)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [RW-1:0] wr_row,
    input  logic [AW-1:0] rd_addr,
    output logic [RW-1:0] rd_row
);
    logic [RW-1:0] mem_q [N_VAR];

    always_ff @(posedge clk) begin
        if (wr_en && (int'(wr_addr) < N_VAR))
            mem_q[wr_addr] <= wr_row;
    end

    assign rd_row = (int'(rd_addr) < N_VAR) ? mem_q[rd_addr] : '0;

    // Stored row indices must address an existing check
    assert_row_in_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (int'(wr_row) < N_CHK));
endmodule

// File: rtl/colsyn_toggle.sv
module colsyn_toggle #(
    parameter int N_CHK = 100,
    localparam int RW = $clog2(N_CHK)
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic                                   active,
    input  logic                                   cur_bit,
    input  logic [colsyn_pkg::COL_WEIGHT-1:0][RW-1:0] rows,
    output logic [N_CHK-1:0]                       flip_mask
);
    // Each memory output toggles its row; repeated rows cancel by XOR
    always_comb begin
        flip_mask = '0;
        if (active && cur_bit) begin
            for (int k = 0; k < colsyn_pkg::COL_WEIGHT; k++) begin
                if (int'(rows[k]) < N_CHK)
                    flip_mask[rows[k]] = flip_mask[rows[k]] ^ 1'b1;
            end
        end
    end

    // R5: no more toggles than column ones; a zero bit toggles nothing
    always_comb begin
        if (rst_n) begin
            assert_mask_weight_R5: assert ($countones(flip_mask) <= colsyn_pkg::COL_WEIGHT);
        end
    end
    assert_zero_bit_quiet_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !cur_bit |-> (flip_mask == '0));
endmodule

// File: rtl/colsyn_top.sv
module colsyn_top #(
    parameter int N_VAR = 1000,
    parameter int N_CHK = 100,
    localparam int AW = $clog2(N_VAR),
    localparam int RW = $clog2(N_CHK)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             smp_wr,
    input  logic [AW-1:0]    smp_addr,
    input  logic [1:0]       smp_val,
    input  logic             hmem_wr,
    input  logic [1:0]       hmem_sel,
    input  logic [AW-1:0]    hmem_addr,
    input  logic [RW-1:0]    hmem_row,
    input  logic             start,
    output logic             busy,
    output logic             done,
    output logic             all_satisfied,
    output logic [N_CHK-1:0] syndrome
);
    import colsyn_pkg::*;

    colsyn_state_e state_q, state_d;
    logic [AW-1:0] col_ptr_q;
    logic          last_col;
    logic          load_open;
    logic          cur_bit;
    logic [COL_WEIGHT-1:0][RW-1:0] rows;
    logic [N_CHK-1:0] flip_mask;
    logic [N_CHK-1:0] syn_q;

    assign load_open = (state_q == ST_IDLE);
    assign last_col  = (int'(col_ptr_q) == N_VAR - 1);

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (start)    state_d = ST_SCAN;
            ST_SCAN:   if (last_col) state_d = ST_FINISH;
            ST_FINISH:               state_d = ST_IDLE;
            default:                 state_d = ST_IDLE;
        endcase
    end

    // Outputs decoded from state
    always_comb begin
        busy = 1'b0;
        done = 1'b0;
        unique case (state_q)
            ST_IDLE:   ;
            ST_SCAN:   busy = 1'b1;
            ST_FINISH: done = 1'b1;
            default:   ;
        endcase
    end

    // Column pointer and syndrome register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_ptr_q <= '0;
            syn_q     <= '0;
        end else if (state_q == ST_IDLE && start) begin
            col_ptr_q <= '0;
            syn_q     <= '0;
        end else if (state_q == ST_SCAN) begin
            syn_q     <= syn_q ^ flip_mask;
            col_ptr_q <= last_col ? '0 : col_ptr_q + 1'b1;
        end
    end

    assign syndrome      = syn_q;
    assign all_satisfied = ~|syn_q;

    colsyn_bitbuf #(.N_VAR(N_VAR)) u_bitbuf (
        .clk       (clk),
        .wr_en     (smp_wr && load_open),
        .wr_addr   (smp_addr),
        .wr_sample (smp_val),
        .rd_addr   (col_ptr_q),
        .rd_bit    (cur_bit)
    );

    for (genvar g = 0; g < COL_WEIGHT; g++) begin : g_rowmem
        colsyn_rowmem #(.N_VAR(N_VAR), .N_CHK(N_CHK)) u_rowmem (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (hmem_wr && load_open && (int'(hmem_sel) == g)),
            .wr_addr (hmem_addr),
            .wr_row  (hmem_row),
            .rd_addr (col_ptr_q),
            .rd_row  (rows[g])
        );
    end

    colsyn_toggle #(.N_CHK(N_CHK)) u_toggle (
        .clk       (clk),
        .rst_n     (rst_n),
        .active    (state_q == ST_SCAN),
        .cur_bit   (cur_bit),
        .rows      (rows),
        .flip_mask (flip_mask)
    );

    // Assertions
    assert_ptr_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (int'(col_ptr_q) < N_VAR));
    assert_clear_on_start_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !done && start) |=> (busy && syndrome == '0 && col_ptr_q == '0));
    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_done_after_scan_R7: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(busy));
    assert_busy_done_excl_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));
    assert_ptr_steps_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !last_col) |=> (busy && col_ptr_q == $past(col_ptr_q) + 1'b1));
    assert_hold_when_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done || (!busy && !start)) |=> $stable(syndrome));
    assert_hmem_sel_R9: assert property (@(posedge clk) disable iff (!rst_n)
        hmem_wr |-> (hmem_sel != 2'd3));
endmodule

// File: tb/tb_colsyn_top.sv
module tb_colsyn_top;
    localparam int N  = 12;
    localparam int M  = 6;
    localparam int AW = $clog2(N);
    localparam int RW = $clog2(M);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic smp_wr = 1'b0;
    logic [AW-1:0] smp_addr = '0;
    logic [1:0] smp_val = '0;
    logic hmem_wr = 1'b0;
    logic [1:0] hmem_sel = '0;
    logic [AW-1:0] hmem_addr = '0;
    logic [RW-1:0] hmem_row = '0;
    logic start = 1'b0;
    logic busy, done, all_satisfied;
    logic [M-1:0] syndrome;

    int checks = 0;
    int errors = 0;
    int hrow [N][3];
    logic [N-1:0] word;
    int busy_cycles;
    bit got_done;
    int unsigned lcg = 32'h1234_5678;

    always #5 clk = ~clk;

    colsyn_top #(.N_VAR(N), .N_CHK(M)) dut (
        .clk(clk), .rst_n(rst_n),
        .smp_wr(smp_wr), .smp_addr(smp_addr), .smp_val(smp_val),
        .hmem_wr(hmem_wr), .hmem_sel(hmem_sel), .hmem_addr(hmem_addr), .hmem_row(hmem_row),
        .start(start), .busy(busy), .done(done),
        .all_satisfied(all_satisfied), .syndrome(syndrome)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [M-1:0] expect_syn(input logic [N-1:0] w);
        logic [M-1:0] s = '0;
        for (int c = 0; c < N; c++)
            for (int k = 0; k < 3; k++)
                if (w[c]) s[hrow[c][k]] = s[hrow[c][k]] ^ 1'b1;
        return s;
    endfunction

    task automatic write_h(input int c, input int k, input int r);
        @(negedge clk);
        hmem_wr = 1'b1; hmem_sel = 2'(k); hmem_addr = AW'(c); hmem_row = RW'(r);
        @(negedge clk);
        hmem_wr = 1'b0;
    endtask

    task automatic load_matrix();
        for (int c = 0; c < N; c++) begin
            hrow[c][0] = c % M;
            hrow[c][1] = (c + 1) % M;
            hrow[c][2] = (c + 3) % M;
            for (int k = 0; k < 3; k++) write_h(c, k, hrow[c][k]);
        end
    endtask

    // Low sample bit varies with position to show it is ignored (R1)
    task automatic load_word(input logic [N-1:0] w, input bit low);
        for (int c = 0; c < N; c++) begin
            @(negedge clk);
            smp_wr = 1'b1; smp_addr = AW'(c);
            smp_val = {w[c], low ^ c[0]};
        end
        @(negedge clk);
        smp_wr = 1'b0;
    endtask

    // Pulses start, counts busy cycles, returns at the negedge where done is high
    task automatic run_pass(input bit poke);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        busy_cycles = 0;
        got_done = 1'b0;
        for (int t = 0; t < 4 * N; t++) begin
            if (done) begin got_done = 1'b1; break; end
            if (busy) begin
                busy_cycles++;
                if (poke && busy_cycles == 3) begin
                    start = 1'b1;
                    smp_wr = 1'b1; smp_addr = '0; smp_val = {~word[0], 1'b0};
                    hmem_wr = 1'b1; hmem_sel = 2'd0; hmem_addr = AW'(N - 1); hmem_row = RW'((hrow[N-1][0] + 1) % M);
                end else begin
                    start = 1'b0; smp_wr = 1'b0; hmem_wr = 1'b0;
                end
            end
            @(negedge clk);
        end
        start = 1'b0; smp_wr = 1'b0; hmem_wr = 1'b0;
    endtask

    task automatic pass_and_check(input logic [N-1:0] w, input bit low, input string req);
        logic [M-1:0] e;
        word = w;
        load_word(w, low);
        run_pass(1'b0);
        e = expect_syn(w);
        check(got_done, "R7", 32'(got_done), 1);
        check(syndrome == e, req, 32'(syndrome), 32'(e));
        check(all_satisfied == (e == '0), "R8", 32'(all_satisfied), 32'(e == '0));
    endtask

    initial begin : watchdog
        repeat (190000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [M-1:0] first;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: reset state
        check(!busy && !done, "R2", {busy, done}, 0);
        check(syndrome == '0 && all_satisfied, "R2", {syndrome, all_satisfied}, 1);

        load_matrix();

        // R3/R7: pass length and done pulse
        pass_and_check('0, 1'b0, "R4");
        check(busy_cycles == N, "R3", busy_cycles, N);
        check(!busy, "R7", busy, 0);
        @(negedge clk);
        check(!done, "R7", done, 0);

        // R1: sign bit only; low bit flipped gives same result
        pass_and_check(12'hA5C, 1'b0, "R1");
        pass_and_check(12'hA5C, 1'b1, "R1");

        // R4: all single and double bit patterns
        for (int i = 0; i < N; i++) begin
            pass_and_check(N'(1) << i, 1'b0, "R4");
            for (int j = i + 1; j < N; j++)
                pass_and_check((N'(1) << i) | (N'(1) << j), 1'b1, "R4");
        end
        pass_and_check('1, 1'b0, "R4");
        for (int r = 0; r < 40; r++) begin
            lcg = lcg * 32'd1103515245 + 32'd12345;
            pass_and_check(N'(lcg >> 7), r[0], "R4");
        end

        // R6: repeat on unchanged data gives same vector
        pass_and_check(12'h3C9, 1'b0, "R6");
        first = syndrome;
        run_pass(1'b0);
        check(syndrome == first, "R6", 32'(syndrome), 32'(first));

        // R9/R10: writes and start during busy are dropped
        word = 12'h5E1;
        load_word(word, 1'b0);
        run_pass(1'b1);
        check(busy_cycles == N, "R10", busy_cycles, N);
        check(syndrome == expect_syn(word), "R9", 32'(syndrome), 32'(expect_syn(word)));
        @(negedge clk);
        check(!busy, "R10", busy, 0);
        run_pass(1'b0);
        check(syndrome == expect_syn(word), "R9", 32'(syndrome), 32'(expect_syn(word)));

        // R5: column 0 with two memories naming the same row
        hrow[0][1] = hrow[0][0];
        write_h(0, 1, hrow[0][0]);
        pass_and_check(12'h001, 1'b0, "R5");
        check(syndrome[hrow[0][0]] == 1'b0, "R5", 32'(syndrome), 32'(expect_syn(12'h001)));
        pass_and_check(12'h7F3, 1'b1, "R5");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule